// File: doc/BRIEF.md
# Timer Channel Compare and Pin Controller

This block sits between an eight-channel timer and a bidirectional port. It is configured through a small register bus. Each channel works either as an input capture or as an output compare. A capture channel records the free-running counter value when its pin rises. A compare channel watches for the counter to equal its compare value. On a match it sets its flag and applies a two-bit action to that channel's output latch.

A software write can also force the compare action at once, and a forced action leaves the flag alone. Channel 7, the highest channel, can drive several pins at the same time through a steering mask. Each pin is driven either by the timer or by the general-purpose data and direction registers. Data written to the port while the timer owns a pin is kept, and it appears on the pin once the timer releases that pin.

Register map (4-bit address, 8-bit data):

| Address | Register |
|---|---|
| 0x0 | Mode |
| 0x1 | Force |
| 0x2 | Steering mask |
| 0x3 | Flags (write 1 to clear) |
| 0x4 | Channel-7 data |
| 0x5 | Actions for channels 0 to 3 |
| 0x6 | Actions for channels 4 to 7 |
| 0x7 | Port data |
| 0x8 | Port direction |
| 0x9 | Pin input status (read only) |

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and pin_oe_o, flag_o and pin_o are all 0.
- R2: Mode bit n at address 0x0 selects output compare when it is 1 and input capture when it is 0. On a capture channel, a rising edge of pin_i[n] loads cnt_i into cap_o[n] and sets flag n at the next clock edge. A register read returns its stored value combinationally.
- R3: On an output compare channel, cnt_i equal to its compare value sets flag n and applies the channel's action. The action for channel n is held in bits [2n+1:2n] of 0x5 for n<4, and in bits [2(n-4)+1:2(n-4)] of 0x6 for n>=4. The codes are 00 no change, 01 toggle, 10 drive 0, 11 drive 1.
- R4: Writing 1 to bit n at 0x1 applies the action of compare channel n in that cycle and does not set flag n. Reads of 0x1 return 0x00.
- R5: A pin is owned by the timer when its mode bit is 1 and either its action is not 00 or its steering mask bit at 0x2 is set. An owned pin has pin_oe_o high whatever its direction bit holds. The direction register (0x8) keeps the value written to it.
- R6: A port data write (0x7) does not change an owned pin. Once the pin is released, it drives the last value written.
- R7: A match or force on channel 7 while it is in compare mode drives each pin whose mask bit is set to the matching bit of 0x4. A force does not set flag 7.
- R8: When channel 7 and channel n act on pin n in the same cycle, channel 7's value is the one taken.
- R9: Writing 1 to bit n at 0x3 clears flag n. A set event in the same cycle takes priority over the clear.
- R10: A pin that is not owned drives pin_o from its port data bit, with pin_oe_o equal to its direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data (combinational) |
| cnt_i | input | 16 | Free-running counter value |
| cmp_i | input | 128 | Compare values, channel n at bits [16n+15:16n] |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables |
| flag_o | output | 8 | Channel flags |
| cap_o | output | 128 | Captured counter values, channel n at bits [16n+15:16n] |

## Verification
Register writes, compare matches, forces and capture edges all take effect at the first rising edge after the inputs are presented. Their results on pin_o, pin_oe_o, flag_o and cap_o are due one edge after the stimulus. Read data is due in the same cycle as the address. The bench therefore drives inputs on the falling edge and checks rdata_o shortly afterwards, before the next rising edge. It checks all other outputs on the following falling edge, against a bench model that is advanced once per rising edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TGL  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  localparam logic [AW-1:0] A_MODE = 4'h0;
  localparam logic [AW-1:0] A_FRC  = 4'h1;
  localparam logic [AW-1:0] A_MASK = 4'h2;
  localparam logic [AW-1:0] A_FLAG = 4'h3;
  localparam logic [AW-1:0] A_C7D  = 4'h4;
  localparam logic [AW-1:0] A_ACT0 = 4'h5;
  localparam logic [AW-1:0] A_ACT1 = 4'h6;
  localparam logic [AW-1:0] A_PORT = 4'h7;
  localparam logic [AW-1:0] A_DIR  = 4'h8;
  localparam logic [AW-1:0] A_PIN  = 4'h9;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NCH-1:0]   wdata_i,
  input  logic [NCH-1:0]   pin_i,
  input  logic [NCH-1:0]   flag_i,
  output logic [NCH-1:0]   rdata_o,
  output logic [NCH-1:0]   mode_o,
  output logic [NCH-1:0]   mask_o,
  output logic [NCH-1:0]   c7d_o,
  output logic [2*NCH-1:0] act_o,
  output logic [NCH-1:0]   port_o,
  output logic [NCH-1:0]   dir_o,
  output logic [NCH-1:0]   frc_o,
  output logic [NCH-1:0]   fclr_o
);
  logic [NCH-1:0]   mode_q, mask_q, c7d_q, port_q, dir_q;
  logic [2*NCH-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '0;
      c7d_q  <= '0;
      port_q <= '0;
      dir_q  <= '0;
      act_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MODE:  mode_q <= wdata_i;
        A_MASK:  mask_q <= wdata_i;
        A_C7D:   c7d_q  <= wdata_i;
        A_ACT0:  act_q[NCH-1:0] <= wdata_i;
        A_ACT1:  act_q[2*NCH-1:NCH] <= wdata_i;
        A_PORT:  port_q <= wdata_i;
        A_DIR:   dir_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // force and clear strobes last one cycle only
  assign frc_o  = (we_i && addr_i == A_FRC)  ? wdata_i : '0;
  assign fclr_o = (we_i && addr_i == A_FLAG) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_MASK:  rdata_o = mask_q;
      A_FLAG:  rdata_o = flag_i;
      A_C7D:   rdata_o = c7d_q;
      A_ACT0:  rdata_o = act_q[NCH-1:0];
      A_ACT1:  rdata_o = act_q[2*NCH-1:NCH];
      A_PORT:  rdata_o = port_q;
      A_DIR:   rdata_o = dir_q;
      A_PIN:   rdata_o = pin_i;
      default: rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign c7d_o  = c7d_q;
  assign act_o  = act_q;
  assign port_o = port_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          pin_i,
  input  logic          frc_i,
  input  logic          clr_i,
  output logic          evt_o,
  output logic          flag_o,
  output logic [CW-1:0] cap_o
);
  logic          pin_q, flag_q, match, rise, set;
  logic [CW-1:0] cap_q;

  assign match = mode_i && (cnt_i == cmp_i);
  assign rise  = !mode_i && pin_i && !pin_q;
  assign set   = match || rise;
  assign evt_o = mode_i && (match || frc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      pin_q  <= pin_i;
      flag_q <= set | (flag_q & ~clr_i);
      if (rise) cap_q <= cnt_i;
    end
  end

  assign flag_o = flag_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/tmr_pin_mux.sv
module tmr_pin_mux
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   evt_i,
  input  logic [2*NCH-1:0] act_i,
  input  logic [NCH-1:0]   mode_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic [NCH-1:0]   c7d_i,
  input  logic [NCH-1:0]   port_i,
  input  logic [NCH-1:0]   dir_i,
  output logic [NCH-1:0]   oc_o,
  output logic [NCH-1:0]   pin_o,
  output logic [NCH-1:0]   oe_o
);
  localparam int unsigned TOP = NCH - 1;

  logic [NCH-1:0] oc_q, oc_d, own;

  for (genvar n = 0; n < NCH; n++) begin : g_pin
    act_e act;
    assign act = act_e'(act_i[2*n +: 2]);

    always_comb begin
      oc_d[n] = oc_q[n];
      if (evt_i[n]) begin
        case (act)
          ACT_TGL: oc_d[n] = ~oc_q[n];
          ACT_CLR: oc_d[n] = 1'b0;
          ACT_SET: oc_d[n] = 1'b1;
          default: oc_d[n] = oc_q[n];
        endcase
      end
      // top channel steering overrides the pin's own action
      if (evt_i[TOP] && mask_i[n]) oc_d[n] = c7d_i[n];
    end

    assign own[n]   = mode_i[n] && ((act != ACT_NONE) || mask_i[n]);
    assign pin_o[n] = own[n] ? oc_q[n] : port_i[n];
    assign oe_o[n]  = own[n] ? 1'b1    : dir_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_q <= '0;
    else         oc_q <= oc_d;
  end

  assign oc_o = oc_q;
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [NCH-1:0]    wdata_i,
  input  logic              we_i,
  output logic [NCH-1:0]    rdata_o,
  input  logic [CW-1:0]     cnt_i,
  input  logic [NCH*CW-1:0] cmp_i,
  input  logic [NCH-1:0]    pin_i,
  output logic [NCH-1:0]    pin_o,
  output logic [NCH-1:0]    pin_oe_o,
  output logic [NCH-1:0]    flag_o,
  output logic [NCH*CW-1:0] cap_o
);
  logic [NCH-1:0]   mode_q, mask_q, c7d_q, port_q, dir_q, oc_q;
  logic [NCH-1:0]   frc, fclr, evt;
  logic [2*NCH-1:0] act_q;

  tmr_regs #(.NCH(NCH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pin_i   (pin_i),
    .flag_i  (flag_o),
    .rdata_o (rdata_o),
    .mode_o  (mode_q),
    .mask_o  (mask_q),
    .c7d_o   (c7d_q),
    .act_o   (act_q),
    .port_o  (port_q),
    .dir_o   (dir_q),
    .frc_o   (frc),
    .fclr_o  (fclr)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tmr_chan #(.CW(CW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_q[n]),
      .cnt_i  (cnt_i),
      .cmp_i  (cmp_i[n*CW +: CW]),
      .pin_i  (pin_i[n]),
      .frc_i  (frc[n]),
      .clr_i  (fclr[n]),
      .evt_o  (evt[n]),
      .flag_o (flag_o[n]),
      .cap_o  (cap_o[n*CW +: CW])
    );
  end

  tmr_pin_mux #(.NCH(NCH)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .act_i  (act_q),
    .mode_i (mode_q),
    .mask_i (mask_q),
    .c7d_i  (c7d_q),
    .port_i (port_q),
    .dir_i  (dir_q),
    .oc_o   (oc_q),
    .pin_o  (pin_o),
    .oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/tmr_pin_ctrl_chk.sv
module tmr_pin_ctrl_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic [NCH-1:0]    wdata_i,
  input logic              we_i,
  input logic [NCH-1:0]    rdata_o,
  input logic [CW-1:0]     cnt_i,
  input logic [NCH*CW-1:0] cmp_i,
  input logic [NCH-1:0]    pin_i,
  input logic [NCH-1:0]    pin_o,
  input logic [NCH-1:0]    pin_oe_o,
  input logic [NCH-1:0]    flag_o,
  input logic [NCH-1:0]    mode_q,
  input logic [NCH-1:0]    mask_q,
  input logic [NCH-1:0]    c7d_q,
  input logic [2*NCH-1:0]  act_q,
  input logic [NCH-1:0]    port_q,
  input logic [NCH-1:0]    oc_q
);
  localparam int unsigned TOP = NCH - 1;

  logic [NCH-1:0] pin_d, set_c, own_c;
  logic           top_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d <= '0;
    else         pin_d <= pin_i;
  end

  assign top_act = mode_q[TOP] &&
                   ((cnt_i == cmp_i[TOP*CW +: CW]) || (we_i && addr_i == A_FRC && wdata_i[TOP]));

  p_force_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_FRC |-> rdata_o == '0);

  p_port_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_PORT |=> port_q == $past(wdata_i));

  for (genvar n = 0; n < NCH; n++) begin : g_n
    assign set_c[n] = (mode_q[n] && cnt_i == cmp_i[n*CW +: CW]) ||
                      (!mode_q[n] && pin_i[n] && !pin_d[n]);
    assign own_c[n] = mode_q[n] && (act_q[2*n +: 2] != 2'b00 || mask_q[n]);

    p_force_no_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == A_FRC && wdata_i[n] && !flag_o[n] && !set_c[n] |=> !flag_o[n]);

    p_clear_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == A_FLAG && wdata_i[n] && !set_c[n] |=> !flag_o[n]);

    p_set_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_c[n] |=> flag_o[n]);

    p_owned_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_c[n] |-> pin_oe_o[n]);

    p_owned_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_c[n] && $past(own_c[n]) && $stable(oc_q[n]) |-> $stable(pin_o[n]));

    p_top_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      top_act && mask_q[n] |=> oc_q[n] == $past(c7d_q[n]));
  end
endmodule

bind tmr_pin_ctrl tmr_pin_ctrl_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .cnt_i    (cnt_i),
  .cmp_i    (cmp_i),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .flag_o   (flag_o),
  .mode_q   (mode_q),
  .mask_q   (mask_q),
  .c7d_q    (c7d_q),
  .act_q    (act_q),
  .port_q   (port_q),
  .oc_q     (oc_q)
);

// File: tb/tmr_pin_ctrl_bench.sv
module tmr_pin_ctrl_bench;
  import tmr_pkg::*;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [AW-1:0]     addr_i = '0;
  logic [NCH-1:0]    wdata_i = '0;
  logic              we_i = 1'b0;
  logic [NCH-1:0]    rdata_o;
  logic [CW-1:0]     cnt_i = '0;
  logic [NCH*CW-1:0] cmp_i;
  logic [NCH-1:0]    pin_i = '0;
  logic [NCH-1:0]    pin_o, pin_oe_o, flag_o;
  logic [NCH*CW-1:0] cap_o;

  always #5 clk = ~clk;

  tmr_pin_ctrl #(.NCH(NCH), .CW(CW)) u_tmr_pin_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .cnt_i(cnt_i), .cmp_i(cmp_i), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .flag_o(flag_o), .cap_o(cap_o)
  );

  logic [CW-1:0]  cmpv [NCH];
  logic [CW-1:0]  m_cap [NCH];
  logic [NCH-1:0] m_mode, m_mask, m_c7d, m_port, m_dir, m_oc, m_flag, m_pprev;
  logic [2*NCH-1:0] m_act;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always_comb
    for (int n = 0; n < NCH; n++) cmp_i[n*CW +: CW] = cmpv[n];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic m_own(input int n);
    return m_mode[n] && (m_act[2*n +: 2] != 2'b00 || m_mask[n]);
  endfunction

  function automatic logic [NCH-1:0] m_read(input logic [AW-1:0] a);
    case (a)
      A_MODE: return m_mode;
      A_MASK: return m_mask;
      A_FLAG: return m_flag;
      A_C7D:  return m_c7d;
      A_ACT0: return m_act[7:0];
      A_ACT1: return m_act[15:8];
      A_PORT: return m_port;
      A_DIR:  return m_dir;
      A_PIN:  return pin_i;
      default: return '0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] m_pin();
    logic [NCH-1:0] r;
    for (int n = 0; n < NCH; n++) r[n] = m_own(n) ? m_oc[n] : m_port[n];
    return r;
  endfunction

  function automatic logic [NCH-1:0] m_oe();
    logic [NCH-1:0] r;
    for (int n = 0; n < NCH; n++) r[n] = m_own(n) ? 1'b1 : m_dir[n];
    return r;
  endfunction

  task automatic m_update(input logic we, input logic [AW-1:0] a, input logic [NCH-1:0] d,
                          input logic [CW-1:0] c, input logic [NCH-1:0] p);
    logic [NCH-1:0] pe, frc, clr, evt, setf, noc;
    pe  = p & ~m_pprev;
    frc = (we && a == A_FRC)  ? d : '0;
    clr = (we && a == A_FLAG) ? d : '0;
    noc = m_oc;
    for (int n = 0; n < NCH; n++) begin
      logic mt, cp;
      mt = m_mode[n] && c == cmpv[n];
      cp = !m_mode[n] && pe[n];
      evt[n]  = m_mode[n] && (mt || frc[n]);
      setf[n] = mt || cp;
      if (cp) m_cap[n] = c;
      if (evt[n])
        case (m_act[2*n +: 2])
          2'b01: noc[n] = ~m_oc[n];
          2'b10: noc[n] = 1'b0;
          2'b11: noc[n] = 1'b1;
          default: ;
        endcase
    end
    for (int n = 0; n < NCH; n++)
      if (evt[NCH-1] && m_mask[n]) noc[n] = m_c7d[n];
    m_oc    = noc;
    m_flag  = setf | (m_flag & ~clr);
    m_pprev = p;
    if (we)
      case (a)
        A_MODE: m_mode = d;
        A_MASK: m_mask = d;
        A_C7D:  m_c7d  = d;
        A_ACT0: m_act[7:0]  = d;
        A_ACT1: m_act[15:8] = d;
        A_PORT: m_port = d;
        A_DIR:  m_dir  = d;
        default: ;
      endcase
  endtask

  // called on a falling edge; leaves time on the next falling edge
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [NCH-1:0] d,
                      input logic [CW-1:0] c, input logic [NCH-1:0] p);
    we_i = we; addr_i = a; wdata_i = d; cnt_i = c; pin_i = p;
    #1;
    if (a == A_FRC) chk("R4 force reads zero", rdata_o, 0);
    else            chk("R2 readback", rdata_o, m_read(a));
    m_update(we, a, d, c, p);
    @(posedge clk);
    @(negedge clk);
    we_i = 1'b0;
    chk("R5 R10 pin_o", pin_o, m_pin());
    chk("R5 R10 pin_oe_o", pin_oe_o, m_oe());
    chk("R9 flag_o", flag_o, m_flag);
    for (int n = 0; n < NCH; n++) chk("R2 cap_o", cap_o[n*CW +: CW], m_cap[n]);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NCH-1:0] d);
    step(1'b1, a, d, 16'h0000, pin_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < NCH; n++) begin
      cmpv[n] = 16'h1000 + 16'(n) * 16'h0100;
      m_cap[n] = '0;
    end
    {m_mode, m_mask, m_c7d, m_port, m_dir, m_oc, m_flag, m_pprev} = '0;
    m_act = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pin_oe_o", pin_oe_o, 0);
    chk("R1 flag_o", flag_o, 0);
    chk("R1 pin_o", pin_o, 0);
    for (int a = 0; a < 10; a++) begin
      addr_i = AW'(a); #1;
      chk("R1 register reset", rdata_o, 0);
    end
    @(negedge clk);

    // R10 free pins follow port and direction
    wr(A_DIR, 8'hFF);
    wr(A_PORT, 8'hA5);
    chk("R10 pin_o", pin_o, 8'hA5);
    chk("R10 pin_oe_o", pin_oe_o, 8'hFF);

    // R3 actions: ch0 none, ch1 toggle, ch2 clear, ch3 set
    wr(A_MODE, 8'h0F);
    wr(A_ACT0, 8'hE4);
    chk("R3 owned pins start low", pin_o, 8'hA1);
    step(1'b0, A_MODE, 8'h00, 16'h1100, 8'h00);
    chk("R3 toggle pin1", pin_o[1], 1);
    chk("R3 match flag1", flag_o[1], 1);
    step(1'b0, A_MODE, 8'h00, 16'h1300, 8'h00);
    chk("R3 set pin3", pin_o[3], 1);
    step(1'b0, A_MODE, 8'h00, 16'h1000, 8'h00);
    chk("R3 action none keeps pin0 free", pin_o[0], 1);

    // R9 clear, R4 force without flag
    wr(A_FLAG, 8'hFF);
    chk("R9 flags cleared", flag_o, 0);
    wr(A_FRC, 8'h0A);
    chk("R4 force toggles pin1", pin_o[1], 0);
    chk("R4 force leaves flags", flag_o, 0);
    step(1'b1, A_FLAG, 8'h02, 16'h1100, 8'h00);
    chk("R9 set beats clear", flag_o[1], 1);

    // R6 latched port write
    wr(A_PORT, 8'h00);
    chk("R6 owned pin3 unchanged", pin_o[3], 1);
    wr(A_MODE, 8'h00);
    chk("R6 released pins show port", pin_o, 8'h00);

    // R5 ownership overrides direction
    wr(A_DIR, 8'h00);
    wr(A_MODE, 8'h0F);
    chk("R5 owned oe", pin_oe_o, 8'h0E);
    chk("R5 direction kept", m_read(A_DIR), 0);

    // R7 steering by top channel, R8 priority
    wr(A_ACT1, 8'hC0);
    wr(A_MASK, 8'h86);
    wr(A_C7D, 8'h04);
    wr(A_MODE, 8'h8F);
    step(1'b0, A_MODE, 8'h00, 16'h1700, 8'h00);
    chk("R7 pin2 from data", pin_o[2], 1);
    chk("R7 pin7 from data", pin_o[7], 0);
    chk("R7 pin1 from data", pin_o[1], 0);
    wr(A_FLAG, 8'hFF);
    wr(A_FRC, 8'h82);
    chk("R8 top channel wins pin1", pin_o[1], 0);
    chk("R7 force no flag7", flag_o[7], 0);

    // R2 capture on ch4
    step(1'b0, A_MODE, 8'h00, 16'h2345, 8'h10);
    chk("R2 capture value", cap_o[4*CW +: CW], 16'h2345);
    chk("R2 capture flag", flag_o[4], 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [AW-1:0] a;
      logic [CW-1:0] c;
      we = ($urandom % 3) == 0;
      a  = AW'($urandom % 10);
      c  = (($urandom % 4) == 0) ? cmpv[$urandom % NCH] : CW'($urandom);
      step(we, a, NCH'($urandom), c, NCH'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule